// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

The block holds three independent 16-bit down counters behind a byte-wide register bus with a 2-bit address. Addresses 0, 1 and 2 open the count port of channels 0, 1 and 2. Address 3 is a write-only control port. A control word names a channel and sets how its count is transferred as bytes, its counting mode and whether it counts in binary or in four-digit BCD. A control word with access field 00 does something else: it freezes a copy of the channel's live count so that software can read a consistent value while the counter keeps running.

All channels step on a shared count-enable input `tick`, and each drives one output pin. Three waveforms are available: a level that rises at terminal count, a rate generator that dips low for one tick per period, and a near-symmetric square wave. To get an output frequency f from a tick rate F, load round(F / f). With the customary 1193182 Hz tick, a 1 kHz square wave takes a count of 1193.

The register bus is plain. A write takes effect at the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr` while `bus_rd` is high, and the read's effect on byte pointers and the held copy takes place at that edge. The bus has no wait states and no back-pressure.

Top module: `pit_timer`

## Requirements
- R1: After reset every output is low, no channel counts, every count reads 0, each channel runs the terminal-count mode in binary with access type "low then high", and reads of address 3 return 0.
- R2: A write to address 3 decodes bits [7:6] as the channel (00, 01, 10). The value 11 leaves every channel unchanged. Bits [3:1] hold the mode code: 2 or 6 selects the rate generator, 3 or 7 selects the square wave, and 0, 1, 4 and 5 run as terminal-count mode. Bit 0 set to 1 selects BCD counting.
- R3: Bits [5:4] of a control word set the access type: 01 means the low byte only, 10 means the high byte only, and 11 means the low byte and then the high byte through per-channel write and read pointers. A control word clears both pointers. With a single-byte access, a write clears the other byte of the count.
- R4: A control word stops its channel. A new count is loaded and counting restarts at the edge of the write that completes the access pattern. A lone low byte in "low then high" mode changes neither the count nor the output.
- R5: A read of a channel port returns the byte of the live count that the access type selects, and the read does not change the count.
- R6: Access field 00 copies the channel's live count into a held value. Reads return the held value while counting continues, until it has been read completely under the access type. Further copy commands before that point are ignored.
- R7: A loaded count of 0 means 65536 ticks in binary and 10000 in BCD.
- R8: In BCD mode each decrement works digit by digit, and 0000 steps to 9999.
- R9: In terminal-count mode the output goes low on a control word or a load, and rises on the tick that brings the count from 1 to 0. It stays high while the count wraps.
- R10: In rate-generator mode the output is low exactly while the count holds 1. The tick after that reloads the count and the output returns high.
- R11: In square-wave mode with period N, the output is high for ceil(N/2) ticks and low for floor(N/2) ticks. It starts high at load, and the count reloads after reaching 1.
- R12: A count changes only on a clock where `tick` is high and the channel is counting. A load in the same clock as a tick takes the loaded value with no decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Shared count enable; every counting channel steps once per high clock |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | 0 to 2 select a channel port, 3 selects the control port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address and state |
| tmr_out | output | 3 | One waveform output per channel |

## Verification
The hardest states to reach from the ports are terminal count after a zero load, which needs 65536 ticks in binary or 10000 in BCD, and a held copy that must stay frozen while the live count keeps moving. The stimulus therefore drives `tick` for exact runs of cycles, so that a zero load is followed by ticks up to one short of the end and then by the final tick. Copy commands are interleaved with ticks and with repeated copy commands before the held value is read. A load is also made to coincide with a tick. A behavioural model of all three channels runs alongside and compares every output and every read byte on each clock.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int NCH    = 3;
  localparam int ADDR_W = 2;
  localparam int DIGITS = CNT_W / 4;
  localparam int EFF_W  = CNT_W + 1;

  typedef enum logic [1:0] {
    ACC_FREEZE = 2'b00,
    ACC_LO     = 2'b01,
    ACC_HI     = 2'b10,
    ACC_BOTH   = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    RUN_TERM   = 2'd0,
    RUN_RATE   = 2'd1,
    RUN_SQUARE = 2'd2
  } run_e;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [EFF_W-1:0] eff_t;

  typedef struct packed {
    logic ctl_wr;
    logic freeze_cmd;
    logic port_wr;
    logic port_rd;
  } ch_strobe_t;

  function automatic run_e decode_mode(logic [2:0] code);
    case (code)
      3'd2, 3'd6: return RUN_RATE;
      3'd3, 3'd7: return RUN_SQUARE;
      default:    return RUN_TERM;
    endcase
  endfunction

  function automatic cnt_t count_dec(cnt_t c, logic bcd);
    cnt_t r;
    logic borrow;
    r = c;
    borrow = 1'b1;
    if (!bcd) return c - cnt_t'(1);
    for (int d = 0; d < DIGITS; d++) begin
      if (borrow) begin
        if (c[d*4 +: 4] == 4'd0) r[d*4 +: 4] = 4'd9;
        else begin
          r[d*4 +: 4] = c[d*4 +: 4] - 4'd1;
          borrow = 1'b0;
        end
      end
    end
    return r;
  endfunction

  function automatic eff_t count_eff(cnt_t c, logic bcd);
    eff_t acc;
    acc = '0;
    if (c == '0) return bcd ? eff_t'(10 ** DIGITS) : (eff_t'(1) << CNT_W);
    if (!bcd) return eff_t'(c);
    for (int d = DIGITS - 1; d >= 0; d--)
      acc = acc * eff_t'(10) + eff_t'(c[d*4 +: 4]);
    return acc;
  endfunction
endpackage

// File: rtl/pit_bus_decode.sv
module pit_bus_decode
  import pit_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_wr,
  input  logic                         bus_rd,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [3:0]                   ctl_top,
  output ch_strobe_t [NCH-1:0]         strb
);
  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NCH);

  logic             ctl_hit;
  logic [NCH-1:0]   any_ctl;

  assign ctl_hit = bus_wr && (bus_addr == CTL_ADDR);

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      strb[i].ctl_wr     = ctl_hit && (ctl_top[3:2] == 2'(i)) && (ctl_top[1:0] != 2'b00);
      strb[i].freeze_cmd = ctl_hit && (ctl_top[3:2] == 2'(i)) && (ctl_top[1:0] == 2'b00);
      strb[i].port_wr    = bus_wr && (bus_addr == ADDR_W'(i));
      strb[i].port_rd    = bus_rd && (bus_addr == ADDR_W'(i));
      any_ctl[i]         = strb[i].ctl_wr || strb[i].freeze_cmd;
    end
  end

  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(any_ctl)); // R2

  AST_SELECT_11_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_hit && ctl_top[3:2] == 2'b11) |-> (any_ctl == '0)); // R2
endmodule

// File: rtl/pit_down_counter.sv
module pit_down_counter
  import pit_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic stop,
  input  logic load,
  input  logic bcd,
  input  run_e mode,
  input  cnt_t load_val,
  output cnt_t cnt,
  output logic out
);
  cnt_t cnt_q, reload_q, step_val;
  eff_t half_q, load_eff, step_eff;
  logic act_q, out_q;

  always_comb begin
    if (mode != RUN_TERM && cnt_q == cnt_t'(1)) step_val = reload_q;
    else                                          step_val = count_dec(cnt_q, bcd);
    step_eff = count_eff(step_val, bcd);
    load_eff = count_eff(load_val, bcd);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      reload_q <= '0;
      half_q   <= '0;
      act_q    <= 1'b0;
      out_q    <= 1'b0;
    end else if (stop) begin
      act_q <= 1'b0;
      out_q <= (mode != RUN_TERM);
    end else if (load) begin
      cnt_q    <= load_val;
      reload_q <= load_val;
      half_q   <= load_eff >> 1;
      act_q    <= 1'b1;
      case (mode)
        RUN_RATE:   out_q <= (load_val != cnt_t'(1));
        RUN_SQUARE: out_q <= 1'b1;
        default:    out_q <= 1'b0;
      endcase
    end else if (tick && act_q) begin
      cnt_q <= step_val;
      case (mode)
        RUN_RATE:   out_q <= (step_val != cnt_t'(1));
        RUN_SQUARE: out_q <= (step_eff > half_q);
        default:    if (cnt_q == cnt_t'(1)) out_q <= 1'b1;
      endcase
    end
  end

  assign cnt = cnt_q;
  assign out = out_q;

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !stop) |=> (act_q && cnt_q == $past(load_val))); // R4

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !act_q); // R4

  AST_COUNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(tick && act_q)) |=> $stable(cnt_q)); // R12

  AST_TERM_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !stop && !load && tick && mode == RUN_TERM && cnt_q == cnt_t'(1)) |=> out_q); // R9

  AST_RATE_LOW_AT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !stop && mode == RUN_RATE) |-> (out_q == (cnt_q != cnt_t'(1)))); // R10
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  ch_strobe_t        strb,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              tmr_out
);
  run_e              mode_q, mode_use;
  acc_e              acc_q;
  logic              bcd_q, wptr_q, rptr_q, held_q;
  cnt_t              held_val_q, live_cnt, load_val, src_val;
  logic [BYTE_W-1:0] stage_q;
  logic              load, release_held;

  assign mode_use     = strb.ctl_wr ? decode_mode(wdata[3:1]) : mode_q;
  assign load         = strb.port_wr && (acc_q != ACC_BOTH || wptr_q);
  assign release_held = strb.port_rd && held_q && (acc_q != ACC_BOTH || rptr_q);

  always_comb begin
    case (acc_q)
      ACC_LO:  load_val = {{BYTE_W{1'b0}}, wdata};
      ACC_HI:  load_val = {wdata, {BYTE_W{1'b0}}};
      default: load_val = {wdata, stage_q};
    endcase
    src_val = held_q ? held_val_q : live_cnt;
    if (acc_q == ACC_HI || (acc_q == ACC_BOTH && rptr_q))
      rd_byte = src_val[CNT_W-1 -: BYTE_W];
    else
      rd_byte = src_val[BYTE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= RUN_TERM;
      acc_q      <= ACC_BOTH;
      bcd_q      <= 1'b0;
      wptr_q     <= 1'b0;
      rptr_q     <= 1'b0;
      held_q     <= 1'b0;
      held_val_q <= '0;
      stage_q    <= '0;
    end else if (strb.ctl_wr) begin
      mode_q <= mode_use;
      acc_q  <= acc_e'(wdata[5:4]);
      bcd_q  <= wdata[0];
      wptr_q <= 1'b0;
      rptr_q <= 1'b0;
      held_q <= 1'b0;
    end else begin
      if (strb.freeze_cmd && !held_q) begin
        held_q     <= 1'b1;
        held_val_q <= live_cnt;
      end else if (release_held) begin
        held_q <= 1'b0;
      end
      if (strb.port_rd && acc_q == ACC_BOTH) rptr_q <= ~rptr_q;
      if (strb.port_wr && acc_q == ACC_BOTH) begin
        wptr_q <= ~wptr_q;
        if (!wptr_q) stage_q <= wdata;
      end
    end
  end

  pit_down_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .stop     (strb.ctl_wr),
    .load     (load),
    .bcd      (bcd_q),
    .mode     (mode_use),
    .load_val (load_val),
    .cnt      (live_cnt),
    .out      (tmr_out)
  );

  AST_HELD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !strb.port_rd && !strb.ctl_wr) |=> (held_q && $stable(held_val_q))); // R6

  AST_PTR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    strb.ctl_wr |=> (!wptr_q && !rptr_q && !held_q)); // R3

  AST_HALF_WRITE_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.port_wr && acc_q == ACC_BOTH && !wptr_q && !tick) |=> $stable(live_cnt)); // R4
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic [NCH-1:0]    tmr_out
);
  ch_strobe_t [NCH-1:0] strb;
  logic [BYTE_W-1:0]    ch_byte [NCH];

  pit_bus_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .ctl_top  (bus_wdata[7:4]),
    .strb     (strb)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pit_channel u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .strb    (strb[g]),
      .wdata   (bus_wdata),
      .rd_byte (ch_byte[g]),
      .tmr_out (tmr_out[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NCH; i++)
      if (bus_addr == ADDR_W'(i)) bus_rdata = ch_byte[i];
  end
endmodule

// File: tb/pit_timer_test.sv
`timescale 1ns/1ps
module pit_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic [2:0] tmr_out;

  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pit_timer uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_out(tmr_out)
  );

  // ---------------- reference model ----------------
  int m_mode [3], m_bcd [3], m_acc [3], m_v [3], m_n [3], m_act [3], m_out [3];
  int m_wp [3], m_rp [3], m_held [3], m_hv [3], m_stage [3];

  function automatic int full_of(int ch);
    return m_bcd[ch] != 0 ? 10000 : 65536;
  endfunction
  function automatic int eff_of(int ch, int v);
    return v == 0 ? full_of(ch) : v;
  endfunction
  function automatic int to_bcd(int v);
    int r = 0;
    for (int d = 0; d < 4; d++) begin
      r += (v % 10) << (4 * d);
      v /= 10;
    end
    return r;
  endfunction
  function automatic int from_bcd(int raw);
    int r = 0;
    for (int d = 3; d >= 0; d--) r = r * 10 + ((raw >> (4 * d)) & 15);
    return r;
  endfunction
  function automatic int enc(int ch, int v);
    return m_bcd[ch] != 0 ? to_bcd(v) : v;
  endfunction
  function automatic int model_read(int ch);
    int val = m_held[ch] != 0 ? m_hv[ch] : enc(ch, m_v[ch]);
    if (m_acc[ch] == 2 || (m_acc[ch] == 3 && m_rp[ch] != 0)) return (val >> 8) & 255;
    return val & 255;
  endfunction

  task automatic model_reset();
    for (int ch = 0; ch < 3; ch++) begin
      m_mode[ch] = 0; m_bcd[ch] = 0; m_acc[ch] = 3; m_v[ch] = 0; m_n[ch] = 0;
      m_act[ch] = 0; m_out[ch] = 0; m_wp[ch] = 0; m_rp[ch] = 0; m_held[ch] = 0;
      m_hv[ch] = 0; m_stage[ch] = 0;
    end
  endtask

  task automatic model_step(int ch);
    int v0 = m_v[ch];
    int held0 = m_held[ch];
    int rp0 = m_rp[ch];
    int done = 0;
    int raw, code;
    if (bus_rd && int'(bus_addr) == ch) begin
      if (held0 != 0 && (m_acc[ch] != 3 || rp0 != 0)) m_held[ch] = 0;
      if (m_acc[ch] == 3) m_rp[ch] = 1 - rp0;
    end
    if (bus_wr && bus_addr == 2'd3 && int'(bus_wdata[7:6]) == ch) begin
      if (bus_wdata[5:4] == 2'b00) begin
        if (held0 == 0) begin m_held[ch] = 1; m_hv[ch] = enc(ch, v0); end
      end else begin
        code = int'(bus_wdata[3:1]);
        m_mode[ch] = (code == 2 || code == 6) ? 2 : (code == 3 || code == 7) ? 3 : 0;
        m_acc[ch] = int'(bus_wdata[5:4]);
        m_bcd[ch] = int'(bus_wdata[0]);
        m_wp[ch] = 0; m_rp[ch] = 0; m_held[ch] = 0; m_act[ch] = 0;
        m_out[ch] = m_mode[ch] == 0 ? 0 : 1;
        done = 1;
      end
    end
    if (bus_wr && int'(bus_addr) == ch) begin
      if (m_acc[ch] == 3 && m_wp[ch] == 0) begin
        m_stage[ch] = int'(bus_wdata); m_wp[ch] = 1;
      end else begin
        if (m_acc[ch] == 1) raw = int'(bus_wdata);
        else if (m_acc[ch] == 2) raw = int'(bus_wdata) << 8;
        else raw = (int'(bus_wdata) << 8) | m_stage[ch];
        m_wp[ch] = 0;
        m_v[ch] = m_bcd[ch] != 0 ? from_bcd(raw) : raw;
        m_n[ch] = m_v[ch];
        m_act[ch] = 1;
        m_out[ch] = m_mode[ch] == 0 ? 0 : m_mode[ch] == 2 ? int'(m_v[ch] != 1) : 1;
        done = 1;
      end
    end
    if (done == 0 && tick && m_act[ch] != 0) begin
      if (m_mode[ch] == 0) begin
        if (v0 == 1) m_out[ch] = 1;
        m_v[ch] = v0 == 0 ? full_of(ch) - 1 : v0 - 1;
      end else begin
        m_v[ch] = v0 == 1 ? m_n[ch] : (v0 == 0 ? full_of(ch) - 1 : v0 - 1);
        if (m_mode[ch] == 2) m_out[ch] = int'(m_v[ch] != 1);
        else m_out[ch] = int'(eff_of(ch, m_v[ch]) > eff_of(ch, m_n[ch]) / 2);
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else for (int ch = 0; ch < 3; ch++) model_step(ch);
  end

  // ---------------- checking ----------------
  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      for (int ch = 0; ch < 3; ch++)
        check(m_mode[ch] == 2 ? "R10 out" : m_mode[ch] == 3 ? "R11 out" : "R9 out",
              int'(tmr_out[ch]), m_out[ch]);
      if (bus_rd && bus_addr != 2'd3)
        check(m_held[int'(bus_addr)] != 0 ? "R6 read" : "R5 read",
              int'(bus_rdata), model_read(int'(bus_addr)));
    end
  end

  // ---------------- stimulus ----------------
  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output int v);
    bus_rd = 1'b1; bus_addr = a;
    #1 v = int'(bus_rdata);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 outputs", int'(tmr_out), 0);
    bus_read(2'd0, v); check("R1 count ch0", v, 0);
    bus_read(2'd3, v); check("R1 control read", v, 0);
    bus_read(2'd0, v); check("R1 count ch0 high", v, 0);

    // terminal count mode, count 5
    bus_write(2'd3, 8'h30); bus_write(2'd0, 8'h05); bus_write(2'd0, 8'h00);
    run_ticks(4); check("R9 before terminal", int'(tmr_out[0]), 0);
    run_ticks(1); check("R9 at terminal", int'(tmr_out[0]), 1);
    run_ticks(3); check("R9 stays high", int'(tmr_out[0]), 1);

    // rate generator, count 4, low-only
    bus_write(2'd3, 8'h54); bus_write(2'd1, 8'h04);
    run_ticks(3); check("R10 low at one", int'(tmr_out[1]), 0);
    run_ticks(1); check("R10 high after reload", int'(tmr_out[1]), 1);
    run_ticks(20);

    // square wave, BCD 7 then binary 5
    bus_write(2'd3, 8'hB7); bus_write(2'd2, 8'h07); bus_write(2'd2, 8'h00);
    run_ticks(30);
    bus_write(2'd3, 8'h56); bus_write(2'd1, 8'h05);
    check("R11 high at load", int'(tmr_out[1]), 1);
    run_ticks(2); check("R11 high half", int'(tmr_out[1]), 1);
    run_ticks(1); check("R11 low half", int'(tmr_out[1]), 0);
    run_ticks(1); check("R11 low half end", int'(tmr_out[1]), 0);
    run_ticks(1); check("R11 new period", int'(tmr_out[1]), 1);

    // freeze and read while counting
    bus_write(2'd3, 8'h30); bus_write(2'd0, 8'h34); bus_write(2'd0, 8'h12);
    run_ticks(3);
    bus_write(2'd3, 8'h00);
    run_ticks(5);
    bus_write(2'd3, 8'h00);
    bus_read(2'd0, v); check("R6 held low", v, 8'h31);
    bus_read(2'd0, v); check("R6 held high", v, 8'h12);
    bus_read(2'd0, v); check("R5 live low", v, 8'h2C);
    bus_read(2'd0, v); check("R5 live high", v, 8'h12);

    // partial write does not load
    bus_write(2'd3, 8'h30); bus_write(2'd0, 8'h10);
    run_ticks(4);
    bus_read(2'd0, v); check("R4 count kept low", v, 8'h2C);
    bus_read(2'd0, v); check("R4 count kept high", v, 8'h12);
    bus_write(2'd0, 8'h00);
    bus_read(2'd0, v); check("R4 loaded low", v, 8'h10);
    bus_read(2'd0, v); check("R4 loaded high", v, 8'h00);

    // single-byte access types
    bus_write(2'd3, 8'h50); bus_write(2'd1, 8'hAB);
    bus_read(2'd1, v); check("R3 low only", v, 8'hAB);
    bus_write(2'd3, 8'h60); bus_write(2'd1, 8'h5C);
    bus_read(2'd1, v); check("R3 high only", v, 8'h5C);
    bus_write(2'd3, 8'h40);
    run_ticks(1);
    bus_read(2'd1, v); check("R6 held single byte", v, 8'h5C);
    bus_read(2'd1, v); check("R6 released", v, 8'h5B);

    // load coinciding with tick
    tick = 1'b1; bus_write(2'd1, 8'h07); tick = 1'b0;
    bus_write(2'd3, 8'h50);
    bus_read(2'd1, v); check("R12 no decrement on load", v, 8'h00);
    bus_write(2'd3, 8'h60);
    bus_read(2'd1, v); check("R12 loaded high", v, 8'h07);

    // BCD zero load
    bus_write(2'd3, 8'hB1); bus_write(2'd2, 8'h00); bus_write(2'd2, 8'h00);
    run_ticks(1);
    bus_write(2'd3, 8'h80);
    bus_read(2'd2, v); check("R8 wrap low", v, 8'h99);
    bus_read(2'd2, v); check("R8 wrap high", v, 8'h99);
    run_ticks(9998); check("R7 BCD before end", int'(tmr_out[2]), 0);
    run_ticks(1); check("R7 BCD 10000 ticks", int'(tmr_out[2]), 1);

    // binary zero load
    bus_write(2'd3, 8'h30); bus_write(2'd0, 8'h00); bus_write(2'd0, 8'h00);
    run_ticks(65535); check("R7 binary before end", int'(tmr_out[0]), 0);
    run_ticks(1); check("R7 binary 65536 ticks", int'(tmr_out[0]), 1);

    // ignored select and mode aliases
    bus_write(2'd3, 8'hF6);
    check("R2 select 11 ch0", int'(tmr_out[0]), 1);
    check("R2 select 11 ch2", int'(tmr_out[2]), 1);
    bus_write(2'd3, 8'h5C); bus_write(2'd1, 8'h03);
    run_ticks(2); check("R2 code 6 as rate low", int'(tmr_out[1]), 0);
    run_ticks(1); check("R2 code 6 as rate high", int'(tmr_out[1]), 1);
    bus_write(2'd3, 8'h92); bus_write(2'd2, 8'h02);
    check("R2 code 1 as terminal low", int'(tmr_out[2]), 0);
    run_ticks(2); check("R2 code 1 as terminal high", int'(tmr_out[2]), 1);

    // all channels running together with interleaved accesses
    bus_write(2'd3, 8'h14); bus_write(2'd0, 8'h06);
    bus_write(2'd3, 8'h77); bus_write(2'd1, 8'h09); bus_write(2'd1, 8'h00);
    bus_write(2'd3, 8'hB6); bus_write(2'd2, 8'h0A); bus_write(2'd2, 8'h00);
    for (int k = 0; k < 20; k++) begin
      run_ticks(3);
      bus_write(2'd3, 8'h80);
      tick = 1'b1;
      bus_read(2'd2, v);
      bus_read(2'd2, v);
      bus_read(2'd0, v);
      tick = 1'b0;
    end
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule